// File: doc/BRIEF.md
# Calendar clock host register interface

This block connects a real-time calendar clock to an 8-bit parallel microprocessor bus. It samples two chip selects (one active low, one active high), a read strobe, a write strobe and a small address into the system clock domain. It turns a completed write into a one-cycle write strobe for the addressed counter byte, or into mode and command updates for the clock and interval-timer logic. A read drives either the addressed counter byte or a status byte onto the output half of the data bus.

The top address holds two nibbles that are shared. The upper nibble is a mode field that is stored as written. The lower nibble is a command field on writes. Its top bit selects one of two command pages: clock commands or interval-timer commands. On reads, the same nibble returns live status: the internal timing-pulse level, a sticky oscillator-good flag and the counter-busy flag. The bidirectional data bus is modelled as an input port, an output port and an output enable.

Top module: `rtc_host_port`

## Requirements
- R1: A write or read takes effect only while cs1_n is 0 and cs2 is 1; otherwise no strobe fires, mode and command state keep their values, and d_oe stays 0.
- R2: For a selected write to address a below 7, cnt_wr bit a pulses for exactly one cycle two clocks after the rising edge of wr_n, and cnt_wdata carries the bus byte held while wr_n was low.
- R3: d_oe is 1 only when the block is selected, rd_n is 0 and wr_n is 1, one clock after those inputs settle. For addresses 0 to 6, d_out then carries byte a of cnt_rdata (bits 8a+7 to 8a).
- R4: Every selected write to address 7 stores data bits 7:4 in mode, whichever command page is used.
- R5: A write to address 7 with bit 3 = 0 is a clock command: bit 2 = 1 gives one clk_adjust_p pulse, bit 1 = 1 gives one clk_reset_p pulse, and bit 0 sets clk_stop to the written value. A 0 in bit 2 or bit 1 does nothing, and the timer-page state is left unchanged.
- R6: A write to address 7 with bit 3 = 1 is a timer command: bit 2 sets tp_disable, bit 1 = 1 gives one int_reset_p pulse, and bit 0 sets int_stop. The clock-page state is left unchanged.
- R7: A read of address 7 returns mode in bits 7:4, 0 in bit 3, tp_level in bit 2, the oscillator flag in bit 1 and busy in bit 0.
- R8: The oscillator flag is 0 after reset and is cleared whenever osc_running is 0. It stays 0 when osc_running returns to 1. Only a clock-reset command accepted while osc_running is 1 sets it to 1.
- R9: tp_pin_low equals tp_level with tp_disable at 0 and is 0 with tp_disable at 1; the status bit 2 follows tp_level either way.
- R10: Reads never raise cnt_wr or any command pulse, even while busy is 1.
- R11: After reset, mode is 0, clk_stop, int_stop and tp_disable are 0, and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; commits on its rising edge |
| addr | input | ADDR_W | Register address |
| d_in | input | DATA_W | Data bus, input half |
| d_out | output | DATA_W | Data bus, output half |
| d_oe | output | 1 | Output enable for d_out |
| cnt_rdata | input | NUM_CNT*DATA_W | Counter bytes, byte a at bits 8a+7:8a |
| cnt_wr | output | NUM_CNT | One-cycle write strobe per counter byte |
| cnt_wdata | output | DATA_W | Data for counter writes |
| busy | input | 1 | Counters are mid-carry |
| osc_running | input | 1 | Oscillator detector reports activity |
| tp_level | input | 1 | Internal timing-pulse state, 1 = pull low |
| mode | output | DATA_W/2 | Stored mode field |
| clk_adjust_p | output | 1 | Clock adjust command pulse |
| clk_reset_p | output | 1 | Clock reset command pulse |
| clk_stop | output | 1 | Clock stop level |
| int_reset_p | output | 1 | Interval timer reset pulse |
| int_stop | output | 1 | Interval timer stop level |
| tp_disable | output | 1 | Timing-pulse pin disable level |
| tp_pin_low | output | 1 | Open-drain pin pull-down request |

## Verification
The bench builds the block with its default parameters: a 3-bit address and 8-bit data, so there are seven counter bytes and the shared control byte sits at address 7. With these values every counter strobe, both command pages and every status bit can be reached. Stimulus covers the decode of all four chip-select combinations, a write and a read-back of every counter byte, and zero-bit no-ops in each page. It also covers the tp_disable masking and the full sticky oscillator-flag sequence, including a reset command given while the oscillator is stopped.

// File: rtl/rhp_pkg.sv
package rhp_pkg;
  // bit positions inside the command nibble at the control address
  localparam int CMD_PAGE_BIT = 3;
  localparam int CMD_B2       = 2;
  localparam int CMD_B1       = 1;
  localparam int CMD_B0       = 0;

  typedef enum logic {
    PAGE_CLOCK = 1'b0,
    PAGE_TIMER = 1'b1
  } cmd_page_e;
endpackage

// File: rtl/rhp_sample.sv
module rhp_sample #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] d_in,
  output logic              sel_now,
  output logic              rd_now,
  output logic              wr_idle_now,
  output logic [ADDR_W-1:0] addr_now,
  output logic              wr_evt,
  output logic [ADDR_W-1:0] evt_addr,
  output logic [DATA_W-1:0] evt_data
);
  // stage one: current bus sample
  logic              s1_cs1_n, s1_cs2, s1_rd_n, s1_wr_n;
  logic [ADDR_W-1:0] s1_addr;
  logic [DATA_W-1:0] s1_data;
  // stage two: bus as it was one clock earlier (still inside the low WR phase)
  logic              s2_cs1_n, s2_cs2, s2_wr_n;
  logic [ADDR_W-1:0] s2_addr;
  logic [DATA_W-1:0] s2_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_cs1_n <= 1'b1;
      s1_cs2   <= 1'b0;
      s1_rd_n  <= 1'b1;
      s1_wr_n  <= 1'b1;
      s1_addr  <= '0;
      s1_data  <= '0;
      s2_cs1_n <= 1'b1;
      s2_cs2   <= 1'b0;
      s2_wr_n  <= 1'b1;
      s2_addr  <= '0;
      s2_data  <= '0;
    end else begin
      s1_cs1_n <= cs1_n;
      s1_cs2   <= cs2;
      s1_rd_n  <= rd_n;
      s1_wr_n  <= wr_n;
      s1_addr  <= addr;
      s1_data  <= d_in;
      s2_cs1_n <= s1_cs1_n;
      s2_cs2   <= s1_cs2;
      s2_wr_n  <= s1_wr_n;
      s2_addr  <= s1_addr;
      s2_data  <= s1_data;
    end
  end

  always_comb begin
    sel_now     = !s1_cs1_n && s1_cs2;
    rd_now      = !s1_rd_n;
    wr_idle_now = s1_wr_n;
    addr_now    = s1_addr;
    // rising WR: high now, low one sample ago; qualify with the older sample
    wr_evt      = s1_wr_n && !s2_wr_n && !s2_cs1_n && s2_cs2;
    evt_addr    = s2_addr;
    evt_data    = s2_data;
  end
endmodule

// File: rtl/rhp_ctrl.sv
module rhp_ctrl
  import rhp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctrl_evt,
  input  logic [DATA_W-1:0]   evt_data,
  input  logic                osc_running,
  output logic [DATA_W/2-1:0] mode,
  output logic                clk_adjust_p,
  output logic                clk_reset_p,
  output logic                clk_stop,
  output logic                int_reset_p,
  output logic                int_stop,
  output logic                tp_disable,
  output logic                osc_flag
);
  localparam int NIB_W = DATA_W / 2;

  cmd_page_e        page;
  logic             clk_hit, tmr_hit;
  logic [NIB_W-1:0] mode_q, mode_nx;
  logic             adj_q, adj_nx, crst_q, crst_nx, cstop_q, cstop_nx;
  logic             irst_q, irst_nx, istop_q, istop_nx, tpdis_q, tpdis_nx;
  logic             osc_q, osc_nx;

  always_comb begin
    page    = cmd_page_e'(evt_data[CMD_PAGE_BIT]);
    clk_hit = ctrl_evt && (page == PAGE_CLOCK);
    tmr_hit = ctrl_evt && (page == PAGE_TIMER);

    mode_nx  = ctrl_evt ? evt_data[DATA_W-1 -: NIB_W] : mode_q;

    adj_nx   = clk_hit && evt_data[CMD_B2];
    crst_nx  = clk_hit && evt_data[CMD_B1];
    cstop_nx = clk_hit ? evt_data[CMD_B0] : cstop_q;

    tpdis_nx = tmr_hit ? evt_data[CMD_B2] : tpdis_q;
    irst_nx  = tmr_hit && evt_data[CMD_B1];
    istop_nx = tmr_hit ? evt_data[CMD_B0] : istop_q;

    // a stopped oscillator wins over a reset command in the same cycle
    if (!osc_running)  osc_nx = 1'b0;
    else if (crst_nx)  osc_nx = 1'b1;
    else               osc_nx = osc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      adj_q   <= 1'b0;
      crst_q  <= 1'b0;
      cstop_q <= 1'b0;
      irst_q  <= 1'b0;
      istop_q <= 1'b0;
      tpdis_q <= 1'b0;
      osc_q   <= 1'b0;
    end else begin
      mode_q  <= mode_nx;
      adj_q   <= adj_nx;
      crst_q  <= crst_nx;
      cstop_q <= cstop_nx;
      irst_q  <= irst_nx;
      istop_q <= istop_nx;
      tpdis_q <= tpdis_nx;
      osc_q   <= osc_nx;
    end
  end

  assign mode         = mode_q;
  assign clk_adjust_p = adj_q;
  assign clk_reset_p  = crst_q;
  assign clk_stop     = cstop_q;
  assign int_reset_p  = irst_q;
  assign int_stop     = istop_q;
  assign tp_disable   = tpdis_q;
  assign osc_flag     = osc_q;
endmodule

// File: rtl/rhp_rdmux.sv
module rhp_rdmux #(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8,
  parameter int NUM_CNT = 7
) (
  input  logic [ADDR_W-1:0]         addr,
  input  logic [NUM_CNT*DATA_W-1:0] cnt_rdata,
  input  logic [DATA_W-1:0]         status,
  output logic [DATA_W-1:0]         rdata
);
  always_comb begin
    if (int'(addr) >= NUM_CNT) rdata = status;
    else                       rdata = cnt_rdata[int'(addr)*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/rtc_host_port.sv
module rtc_host_port #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  localparam int NUM_CNT = (1 << ADDR_W) - 1,
  localparam int NIB_W   = DATA_W / 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs1_n,
  input  logic                      cs2,
  input  logic                      rd_n,
  input  logic                      wr_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         d_in,
  output logic [DATA_W-1:0]         d_out,
  output logic                      d_oe,
  input  logic [NUM_CNT*DATA_W-1:0] cnt_rdata,
  output logic [NUM_CNT-1:0]        cnt_wr,
  output logic [DATA_W-1:0]         cnt_wdata,
  input  logic                      busy,
  input  logic                      osc_running,
  input  logic                      tp_level,
  output logic [NIB_W-1:0]          mode,
  output logic                      clk_adjust_p,
  output logic                      clk_reset_p,
  output logic                      clk_stop,
  output logic                      int_reset_p,
  output logic                      int_stop,
  output logic                      tp_disable,
  output logic                      tp_pin_low
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CNT);

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_int_n <= rst_meta;
    end
  end

  logic              sel_now, rd_now, wr_idle_now, wr_evt, ctrl_evt, osc_flag;
  logic [ADDR_W-1:0] addr_now, evt_addr;
  logic [DATA_W-1:0] evt_data, rdata, status;

  rhp_sample #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sample (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cs1_n       (cs1_n),
    .cs2         (cs2),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .addr        (addr),
    .d_in        (d_in),
    .sel_now     (sel_now),
    .rd_now      (rd_now),
    .wr_idle_now (wr_idle_now),
    .addr_now    (addr_now),
    .wr_evt      (wr_evt),
    .evt_addr    (evt_addr),
    .evt_data    (evt_data)
  );

  assign ctrl_evt = wr_evt && (evt_addr == CTRL_ADDR);

  rhp_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .ctrl_evt     (ctrl_evt),
    .evt_data     (evt_data),
    .osc_running  (osc_running),
    .mode         (mode),
    .clk_adjust_p (clk_adjust_p),
    .clk_reset_p  (clk_reset_p),
    .clk_stop     (clk_stop),
    .int_reset_p  (int_reset_p),
    .int_stop     (int_stop),
    .tp_disable   (tp_disable),
    .osc_flag     (osc_flag)
  );

  // per-byte counter write strobes
  logic [NUM_CNT-1:0] cnt_wr_nx, cnt_wr_q;
  logic [DATA_W-1:0]  wdata_nx, wdata_q;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_wr
    always_comb cnt_wr_nx[i] = wr_evt && (evt_addr == ADDR_W'(i));
  end

  always_comb wdata_nx = wr_evt ? evt_data : wdata_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cnt_wr_q <= '0;
      wdata_q  <= '0;
    end else begin
      cnt_wr_q <= cnt_wr_nx;
      wdata_q  <= wdata_nx;
    end
  end

  assign cnt_wr    = cnt_wr_q;
  assign cnt_wdata = wdata_q;

  // read side
  assign status = {mode, {(NIB_W-3){1'b0}}, tp_level, osc_flag, busy};

  rhp_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CNT(NUM_CNT)) u_rdmux (
    .addr      (addr_now),
    .cnt_rdata (cnt_rdata),
    .status    (status),
    .rdata     (rdata)
  );

  assign d_oe       = sel_now && rd_now && wr_idle_now;
  assign d_out      = d_oe ? rdata : '0;
  assign tp_pin_low = tp_level && !tp_disable;
endmodule

// File: rtl/rtc_host_port_chk.sv
module rtc_host_port_chk #(
  parameter int ADDR_W  = 3,
  parameter int NUM_CNT = 7,
  parameter int NIB_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cs1_n,
  input logic               cs2,
  input logic               rd_n,
  input logic               wr_n,
  input logic               d_oe,
  input logic [NUM_CNT-1:0] cnt_wr,
  input logic [NIB_W-1:0]   mode,
  input logic               osc_running,
  input logic               osc_flag,
  input logic               ctrl_evt,
  input logic               clk_adjust_p,
  input logic               int_reset_p
);
  // R2: at most one counter byte strobed per cycle
  a_r2_onehot_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cnt_wr));

  // R3 / R1: output enable only after a selected, read-only bus sample
  a_r3_oe_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    d_oe |-> ($past(!rd_n) && $past(wr_n) && $past(!cs1_n) && $past(cs2)));

  // R10: a counter strobe is always preceded by a WR low-to-high transition
  a_r10_strobe_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr != '0) |-> ($past(wr_n, 2) && !$past(wr_n, 3)));

  // R4: mode changes only through a control-address write
  a_r4_mode_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |-> $past(ctrl_evt));

  // R5: adjust pulse lasts a single cycle
  a_r5_adjust_single: assert property (@(posedge clk) disable iff (!rst_n)
    clk_adjust_p |=> !clk_adjust_p);

  // R6: a timer-page command never fires a clock-page pulse with it
  a_r6_pages_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    int_reset_p |-> !clk_adjust_p);

  // R8: a stopped oscillator clears the flag on the next clock
  a_r8_osc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_running |=> !osc_flag);

  // R8: the flag rises only on an accepted control write
  a_r8_osc_rise_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_flag) |-> $past(ctrl_evt));
endmodule

bind rtc_host_port rtc_host_port_chk #(
  .ADDR_W (ADDR_W),
  .NUM_CNT(NUM_CNT),
  .NIB_W  (NIB_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs1_n        (cs1_n),
  .cs2          (cs2),
  .rd_n         (rd_n),
  .wr_n         (wr_n),
  .d_oe         (d_oe),
  .cnt_wr       (cnt_wr),
  .mode         (mode),
  .osc_running  (osc_running),
  .osc_flag     (osc_flag),
  .ctrl_evt     (ctrl_evt),
  .clk_adjust_p (clk_adjust_p),
  .int_reset_p  (int_reset_p)
);

// File: tb/rtc_host_port_tb.sv
module rtc_host_port_tb;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int NC = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs1_n = 1'b1, cs2 = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] d_in = '0;
  logic [DW-1:0] d_out;
  logic d_oe;
  logic [NC*DW-1:0] cnt_rdata = '0;
  logic [NC-1:0] cnt_wr;
  logic [DW-1:0] cnt_wdata;
  logic busy = 1'b0, osc_running = 1'b1, tp_level = 1'b0;
  logic [3:0] mode;
  logic clk_adjust_p, clk_reset_p, clk_stop, int_reset_p, int_stop, tp_disable, tp_pin_low;

  int n_checks = 0;
  int n_errors = 0;
  int n_obs = 0;
  logic [15:0] exp_q[$];

  always #2 clk = ~clk;

  rtc_host_port #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .d_in(d_in), .d_out(d_out), .d_oe(d_oe),
    .cnt_rdata(cnt_rdata), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .busy(busy), .osc_running(osc_running), .tp_level(tp_level),
    .mode(mode), .clk_adjust_p(clk_adjust_p), .clk_reset_p(clk_reset_p),
    .clk_stop(clk_stop), .int_reset_p(int_reset_p), .int_stop(int_stop),
    .tp_disable(tp_disable), .tp_pin_low(tp_pin_low)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard item: {kind[3:0], index[3:0], data[7:0]}; kind 1 counter write (R2),
  // 2 clock adjust (R5), 3 clock reset (R5), 4 timer reset (R6)
  function automatic string req_of(input logic [3:0] kind);
    if (kind == 4'd1) return "R2 counter strobe";
    if (kind == 4'd4) return "R6 timer pulse";
    return "R5 clock pulse";
  endfunction

  task automatic observe(input logic [15:0] item);
    logic [15:0] e;
    n_obs++;
    n_checks++;
    if (exp_q.size() == 0) begin
      n_errors++;
      $display("FAIL R1/R10 unexpected strobe: actual %h expected none", item);
    end else begin
      e = exp_q.pop_front();
      if (e !== item) begin
        n_errors++;
        $display("FAIL %s: actual %h expected %h", req_of(e[15:12]), item, e);
      end
    end
  endtask

  // monitor: samples strobes at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NC; i++)
        if (cnt_wr[i]) observe({4'd1, 4'(i), cnt_wdata});
      if (clk_adjust_p) observe(16'h2000);
      if (clk_reset_p)  observe(16'h3000);
      if (int_reset_p)  observe(16'h4000);
    end
  end

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic c1n, input logic c2);
    @(negedge clk);
    cs1_n = c1n; cs2 = c2; addr = a; d_in = d; wr_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wr_n = 1'b1;
    repeat (2) @(negedge clk);
    cs1_n = 1'b1; cs2 = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic sel_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_wr(a, d, 1'b0, 1'b1);
  endtask

  task automatic bus_rd(input string req, input logic [AW-1:0] a,
                        input logic c1n, input logic c2,
                        input logic exp_oe, input logic [DW-1:0] exp_d);
    @(negedge clk);
    cs1_n = c1n; cs2 = c2; addr = a; rd_n = 1'b0;
    @(negedge clk);
    check(req, {15'd0, d_oe}, {15'd0, exp_oe});
    if (exp_oe) check(req, {8'd0, d_out}, {8'd0, exp_d});
    rd_n = 1'b1; cs1_n = 1'b1; cs2 = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [7:0] stat(input logic [3:0] m, input logic tp,
                                      input logic osc, input logic bz);
    return {m, 1'b0, tp, osc, bz};
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin : main
    int obs_before;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11 reset state
    check("R11 mode", {12'd0, mode}, 16'd0);
    check("R11 levels", {12'd0, clk_stop, int_stop, tp_disable, d_oe}, 16'd0);
    // R7 / R8 status after reset: oscillator flag 0
    bus_rd("R8 status after reset", 3'd7, 1'b0, 1'b1, 1'b1, stat(4'h0, 1'b0, 1'b0, 1'b0));

    // R2 writes to every counter byte
    for (int i = 0; i < NC; i++) begin
      exp_q.push_back({4'd1, 4'(i), 8'(8'h11 * (i + 1))});
      sel_wr(AW'(i), 8'(8'h11 * (i + 1)));
    end

    // R3 read back of counter bytes
    for (int i = 0; i < NC; i++) cnt_rdata[i*DW +: DW] = 8'(8'hA0 + 3 * i);
    for (int i = 0; i < NC; i++)
      bus_rd("R3 counter read", AW'(i), 1'b0, 1'b1, 1'b1, 8'(8'hA0 + 3 * i));

    // R1 unselected combinations: no strobes, no mode change, no drive
    bus_wr(3'd2, 8'h5A, 1'b1, 1'b1);
    bus_wr(3'd2, 8'h5A, 1'b0, 1'b0);
    bus_wr(3'd7, 8'hF5, 1'b1, 1'b0);
    check("R1 mode untouched", {12'd0, mode}, 16'd0);
    check("R1 clk_stop untouched", {15'd0, clk_stop}, 16'd0);
    bus_rd("R1 read unselected", 3'd1, 1'b1, 1'b1, 1'b0, 8'h00);
    bus_rd("R1 read unselected", 3'd1, 1'b0, 1'b0, 1'b0, 8'h00);

    // R4 / R5 clock page: adjust + stop
    exp_q.push_back(16'h2000);
    sel_wr(3'd7, 8'hA5);
    check("R4 mode", {12'd0, mode}, 16'h000A);
    check("R5 clk_stop set", {15'd0, clk_stop}, 16'd1);

    // R5 zero bits are no-ops, bit 0 restarts
    sel_wr(3'd7, 8'h30);
    check("R4 mode", {12'd0, mode}, 16'h0003);
    check("R5 clk_stop cleared", {15'd0, clk_stop}, 16'd0);

    // R6 timer page
    exp_q.push_back(16'h4000);
    sel_wr(3'd7, 8'h7E);
    check("R4 mode", {12'd0, mode}, 16'h0007);
    check("R6 tp_disable/int_stop", {14'd0, tp_disable, int_stop}, 16'b10);
    check("R6 clock page untouched", {15'd0, clk_stop}, 16'd0);
    sel_wr(3'd7, 8'h59);
    check("R6 tp_disable/int_stop", {14'd0, tp_disable, int_stop}, 16'b01);

    // R9 pin masking vs. status flag
    tp_level = 1'b1;
    @(negedge clk);
    check("R9 pin follows level", {15'd0, tp_pin_low}, 16'd1);
    bus_rd("R9 status tp", 3'd7, 1'b0, 1'b1, 1'b1, stat(4'h5, 1'b1, 1'b0, 1'b0));
    sel_wr(3'd7, 8'h5C);
    check("R9 pin released", {15'd0, tp_pin_low}, 16'd0);
    check("R6 int_stop cleared", {15'd0, int_stop}, 16'd0);
    bus_rd("R9 status ignores disable", 3'd7, 1'b0, 1'b1, 1'b1, stat(4'h5, 1'b1, 1'b0, 1'b0));

    // R8 sticky oscillator flag
    exp_q.push_back(16'h3000);
    sel_wr(3'd7, 8'h52);
    bus_rd("R8 flag set by reset", 3'd7, 1'b0, 1'b1, 1'b1, stat(4'h5, 1'b1, 1'b1, 1'b0));
    osc_running = 1'b0;
    repeat (3) @(negedge clk);
    bus_rd("R8 flag cleared", 3'd7, 1'b0, 1'b1, 1'b1, stat(4'h5, 1'b1, 1'b0, 1'b0));
    osc_running = 1'b1;
    repeat (3) @(negedge clk);
    bus_rd("R8 flag stays low", 3'd7, 1'b0, 1'b1, 1'b1, stat(4'h5, 1'b1, 1'b0, 1'b0));
    osc_running = 1'b0;
    exp_q.push_back(16'h3000);
    sel_wr(3'd7, 8'h52);
    bus_rd("R8 reset while stopped", 3'd7, 1'b0, 1'b1, 1'b1, stat(4'h5, 1'b1, 1'b0, 1'b0));
    osc_running = 1'b1;
    exp_q.push_back(16'h3000);
    sel_wr(3'd7, 8'h52);
    bus_rd("R8 flag set again", 3'd7, 1'b0, 1'b1, 1'b1, stat(4'h5, 1'b1, 1'b1, 1'b0));

    // R10 reads while busy produce no strobes
    busy = 1'b1;
    obs_before = n_obs;
    for (int i = 0; i < NC; i++)
      bus_rd("R10 busy read", AW'(i), 1'b0, 1'b1, 1'b1, 8'(8'hA0 + 3 * i));
    bus_rd("R7 busy bit", 3'd7, 1'b0, 1'b1, 1'b1, stat(4'h5, 1'b1, 1'b1, 1'b1));
    repeat (3) @(negedge clk);
    check("R10 no strobe on reads", 16'(n_obs - obs_before), 16'd0);

    // R3 no drive while WR is also low
    @(negedge clk);
    cs1_n = 1'b0; cs2 = 1'b1; addr = 3'd0; rd_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    check("R3 oe with WR low", {15'd0, d_oe}, 16'd0);
    rd_n = 1'b1;
    @(negedge clk);
    cs1_n = 1'b1; cs2 = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);

    check("R2 scoreboard drained", 16'(exp_q.size()), 16'd0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule